// File: doc/BRIEF.md
# Multichannel ADC Step Sequencer

This block drives an external successive-approximation converter across eight analog channels. It only sees the converter through a digital handshake. The block sends a one-cycle start pulse and a channel number. The converter answers with a done strobe and a 12-bit sample. A programmable divider turns the system clock into a converter tick. All sequencing advances on that tick.

Each channel has three settings: an enable bit, a settle delay counted in ticks, and an averaging code. The sequencer visits the enabled channels in ascending order. For each channel it waits out the settle delay. It then collects a power-of-two number of samples, averages them by a right shift, and stores one result with a valid flag. Any stored result can be read through a channel-select readback port. When no channel is enabled, the block returns to idle and drops the converter power enable.

Top module: `adc_step_seq`

## Requirements
- R1: The converter tick recurs every P system clocks. P is the programmed divisor, 2400 after reset. A value written below 10 is replaced by 10. A written value is adopted at the divider's next terminal count.
- R2: Only enabled channels are converted, and `adcChan` names the channel being converted. After the group of channel c, the next group belongs to the next enabled index above c, wrapping round to the lowest enabled index.
- R3: While no channel is enabled, the sequencer returns to idle. In idle `adcPowerEn` is low and `adcStart` never rises. `adcPowerEn` is high on every cycle that carries a start.
- R4: The open delay D of a channel is held in `openDelay[8c+7:8c]`. The first start of that channel's group falls on the (D+2)-th tick after the channel is selected. When done returns within a few clocks, the last start of one group and the first start of the next are therefore (D+2)*P clocks apart.
- R5: Within a group, each further start falls on the first tick after the previous sample's done strobe. Starts inside a group are therefore P clocks apart.
- R6: The stored result is the sum of the group's samples divided by the group size, truncated toward zero. The sum is held in a 16-bit accumulator, so sixteen samples of 4095 store 4095.
- R7: `rdChan` selects a channel. `rdData` and `rdValid` show that channel's stored result and valid flag in the same cycle. `validVec[c]` is the valid flag of channel c. All flags are zero after reset.
- R8: `adcStart` is high for exactly one system clock, and that clock coincides with a converter tick.
- R9: A channel's valid flag is low in the cycle after its enable is seen low. A group that completes while its channel is disabled is not stored.
- R10: The averaging code of channel c is held in `avgSel[3c+2:3c]`. Codes 0, 1, 2 and 3 select groups of 1, 2, 4 and 8 samples. Codes 4 to 7 select 16 samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divWr | input | 1 | Write strobe for the divisor |
| divData | input | 16 | Divisor value, clamped to at least 10 |
| chEnable | input | 8 | Per-channel enable bits |
| openDelay | input | 64 | Settle delay per channel, 8 bits each, in ticks |
| avgSel | input | 24 | Averaging code per channel, 3 bits each |
| rdChan | input | 3 | Readback channel select |
| rdData | output | 12 | Stored result of the selected channel |
| rdValid | output | 1 | Valid flag of the selected channel |
| validVec | output | 8 | Valid flags of all channels |
| adcPowerEn | output | 1 | Converter power enable |
| adcStart | output | 1 | One-cycle conversion start |
| adcChan | output | 3 | Channel being converted |
| adcDone | input | 1 | Conversion complete strobe |
| adcSample | input | 12 | Converted sample, taken when adcDone is high |

## Verification
The properties assume that the converter raises `adcDone` for one clock only. They also assume it does so once after each start and before the next tick. The sequencer accepts a done strobe only while it is waiting for a conversion. The stimulus models the converter to answer three clocks after each start, and it keeps the divisor at or above the clamp floor. With that divisor, the answer always arrives well inside one tick period. Configuration changes are applied between negative clock edges, and that includes turning off a channel whose group is in flight.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_START,
    ST_WAIT,
    ST_STORE
  } seqState_t;

  // strobes from the sequencer control to the datapath
  typedef struct packed {
    logic accClear;
    logic accAdd;
    logic storeEn;
  } dpCtrl_t;

endpackage

// File: rtl/adcseq_prescaler.sv
module adcseq_prescaler #(
  parameter int DIV_W     = 16,
  parameter int DIV_MIN   = 10,
  parameter int DIV_RESET = 2400
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             divWr,
  input  logic [DIV_W-1:0] divData,
  output logic             tick
);
  localparam logic [DIV_W-1:0] MinVal   = DIV_W'(DIV_MIN);
  localparam logic [DIV_W-1:0] ResetVal = DIV_W'(DIV_RESET);

  logic [DIV_W-1:0] pendDiv;
  logic [DIV_W-1:0] actDiv;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] clamped;

  assign clamped = (divData < MinVal) ? MinVal : divData;
  assign tick    = (cnt == actDiv - 1'b1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendDiv <= ResetVal;
      actDiv  <= ResetVal;
      cnt     <= '0;
    end else begin
      if (divWr) pendDiv <= clamped;
      if (tick) begin
        cnt    <= '0;
        actDiv <= pendDiv;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adcseq_ctrl.sv
module adcseq_ctrl
  import adcseq_pkg::*;
#(
  parameter int NUM_CH    = 8,
  parameter int CH_W      = 3,
  parameter int DLY_W     = 8,
  parameter int AVG_W     = 3,
  parameter int MAX_SHIFT = 4,
  parameter int SH_W      = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    tick,
  input  logic [NUM_CH-1:0]       chEnable,
  input  logic [NUM_CH*DLY_W-1:0] openDelay,
  input  logic [NUM_CH*AVG_W-1:0] avgSel,
  input  logic                    adcDone,
  output logic                    adcStart,
  output logic                    adcPowerEn,
  output logic [CH_W-1:0]         curChan,
  output logic [SH_W-1:0]         shiftAmt,
  output dpCtrl_t                 dpCtrl
);
  localparam int SC_W = MAX_SHIFT + 1;

  seqState_t        state;
  logic [CH_W-1:0]  nxtChan;
  logic             nxtFound;
  logic [DLY_W-1:0] dlyCnt;
  logic [DLY_W-1:0] curDelay;
  logic [AVG_W-1:0] curSel;
  logic [SC_W-1:0]  sampCnt;
  logic [SC_W-1:0]  groupLast;
  logic             anyEn;
  logic             curEn;
  logic             skip;

  assign anyEn    = |chEnable;
  assign curEn    = chEnable[curChan];
  assign curDelay = openDelay[curChan*DLY_W +: DLY_W];
  assign curSel   = avgSel[curChan*AVG_W +: AVG_W];
  assign shiftAmt = (curSel > AVG_W'(MAX_SHIFT)) ? SH_W'(MAX_SHIFT) : SH_W'(curSel);
  assign groupLast = (SC_W'(1) << shiftAmt) - SC_W'(1);
  assign skip     = (state == ST_SETTLE || state == ST_START) && anyEn && !curEn;

  // next enabled channel above the current one, wrapping
  always_comb begin
    nxtChan  = curChan;
    nxtFound = 1'b0;
    for (int k = 1; k <= NUM_CH; k++) begin
      if (!nxtFound && chEnable[(int'(curChan) + k) % NUM_CH]) begin
        nxtChan  = CH_W'((int'(curChan) + k) % NUM_CH);
        nxtFound = 1'b1;
      end
    end
  end

  assign adcPowerEn = (state != ST_IDLE);
  assign adcStart   = (state == ST_START) && tick && curEn;

  always_comb begin
    dpCtrl.accAdd   = (state == ST_WAIT) && adcDone;
    dpCtrl.storeEn  = (state == ST_STORE);
    dpCtrl.accClear = (state == ST_IDLE) || (state == ST_STORE) || skip;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      curChan <= CH_W'(NUM_CH - 1);
      dlyCnt  <= '0;
      sampCnt <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (anyEn) begin
            curChan <= nxtChan;
            dlyCnt  <= '0;
            sampCnt <= '0;
            state   <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (!anyEn) begin
            state <= ST_IDLE;
          end else if (skip) begin
            curChan <= nxtChan;
            dlyCnt  <= '0;
            sampCnt <= '0;
          end else if (tick) begin
            if (dlyCnt >= curDelay) state <= ST_START;
            else dlyCnt <= dlyCnt + 1'b1;
          end
        end
        ST_START: begin
          if (!anyEn) begin
            state <= ST_IDLE;
          end else if (skip) begin
            curChan <= nxtChan;
            dlyCnt  <= '0;
            sampCnt <= '0;
            state   <= ST_SETTLE;
          end else if (tick) begin
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (adcDone) begin
            if (sampCnt >= groupLast) begin
              state <= ST_STORE;
            end else begin
              sampCnt <= sampCnt + 1'b1;
              state   <= ST_START;
            end
          end
        end
        ST_STORE: begin
          if (anyEn) begin
            curChan <= nxtChan;
            dlyCnt  <= '0;
            sampCnt <= '0;
            state   <= ST_SETTLE;
          end else begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adcseq_datapath.sv
module adcseq_datapath
  import adcseq_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 3,
  parameter int SMP_W  = 12,
  parameter int ACC_W  = 16,
  parameter int SH_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           dpCtrl,
  input  logic [CH_W-1:0]   chan,
  input  logic [SH_W-1:0]   shiftAmt,
  input  logic [NUM_CH-1:0] chEnable,
  input  logic [SMP_W-1:0]  adcSample,
  input  logic [CH_W-1:0]   rdChan,
  output logic [SMP_W-1:0]  rdData,
  output logic              rdValid,
  output logic [NUM_CH-1:0] validVec
);
  logic [ACC_W-1:0]        acc;
  logic [ACC_W-1:0]        avgVal;
  logic [NUM_CH*SMP_W-1:0] resFlat;

  assign avgVal = acc >> shiftAmt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) acc <= '0;
    else if (dpCtrl.accClear) acc <= '0;
    else if (dpCtrl.accAdd) acc <= acc + ACC_W'(adcSample);
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
    logic [SMP_W-1:0] res;
    logic             vld;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        res <= '0;
        vld <= 1'b0;
      end else if (!chEnable[g]) begin
        vld <= 1'b0;
      end else if (dpCtrl.storeEn && chan == CH_W'(g)) begin
        res <= SMP_W'(avgVal);
        vld <= 1'b1;
      end
    end
    assign resFlat[g*SMP_W +: SMP_W] = res;
    assign validVec[g] = vld;
  end

  assign rdData  = resFlat[rdChan*SMP_W +: SMP_W];
  assign rdValid = validVec[rdChan];
endmodule

// File: rtl/adc_step_seq.sv
module adc_step_seq #(
  parameter int NUM_CH    = 8,
  parameter int SMP_W     = 12,
  parameter int DIV_W     = 16,
  parameter int DIV_MIN   = 10,
  parameter int DIV_RESET = 2400,
  parameter int DLY_W     = 8,
  parameter int AVG_W     = 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    divWr,
  input  logic [DIV_W-1:0]        divData,
  input  logic [NUM_CH-1:0]       chEnable,
  input  logic [NUM_CH*DLY_W-1:0] openDelay,
  input  logic [NUM_CH*AVG_W-1:0] avgSel,
  input  logic [$clog2(NUM_CH)-1:0] rdChan,
  output logic [SMP_W-1:0]        rdData,
  output logic                    rdValid,
  output logic [NUM_CH-1:0]       validVec,
  output logic                    adcPowerEn,
  output logic                    adcStart,
  output logic [$clog2(NUM_CH)-1:0] adcChan,
  input  logic                    adcDone,
  input  logic [SMP_W-1:0]        adcSample
);
  import adcseq_pkg::*;

  localparam int CH_W      = $clog2(NUM_CH);
  localparam int MAX_SHIFT = 4;
  localparam int SH_W      = $clog2(MAX_SHIFT + 1);
  localparam int ACC_W     = SMP_W + MAX_SHIFT;

  logic            convTick;
  logic [SH_W-1:0] shiftAmt;
  dpCtrl_t         dpCtrl;

  adcseq_prescaler #(
    .DIV_W(DIV_W), .DIV_MIN(DIV_MIN), .DIV_RESET(DIV_RESET)
  ) u_div (
    .clk(clk), .rstN(rstN), .divWr(divWr), .divData(divData), .tick(convTick)
  );

  adcseq_ctrl #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .DLY_W(DLY_W), .AVG_W(AVG_W),
    .MAX_SHIFT(MAX_SHIFT), .SH_W(SH_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(convTick), .chEnable(chEnable),
    .openDelay(openDelay), .avgSel(avgSel), .adcDone(adcDone),
    .adcStart(adcStart), .adcPowerEn(adcPowerEn), .curChan(adcChan),
    .shiftAmt(shiftAmt), .dpCtrl(dpCtrl)
  );

  adcseq_datapath #(
    .NUM_CH(NUM_CH), .CH_W(CH_W), .SMP_W(SMP_W), .ACC_W(ACC_W), .SH_W(SH_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .dpCtrl(dpCtrl), .chan(adcChan),
    .shiftAmt(shiftAmt), .chEnable(chEnable), .adcSample(adcSample),
    .rdChan(rdChan), .rdData(rdData), .rdValid(rdValid), .validVec(validVec)
  );
endmodule

// File: rtl/adcseq_checker.sv
module adcseq_checker #(
  parameter int NUM_CH = 8,
  parameter int CH_W   = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] chEnable,
  input logic              adcStart,
  input logic              adcPowerEn,
  input logic [CH_W-1:0]   adcChan,
  input logic [NUM_CH-1:0] validVec,
  input logic              convTick
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |=> !adcStart) else $error("start held longer than one clock"); // R8

  AST_START_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |-> convTick) else $error("start off the converter tick"); // R8

  AST_START_POWERED: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |-> adcPowerEn) else $error("start while converter unpowered"); // R3

  AST_START_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |-> chEnable[adcChan]) else $error("start on a disabled channel"); // R2

  for (genvar i = 0; i < NUM_CH; i++) begin : g_vchk
    AST_VALID_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
      !chEnable[i] |=> !validVec[i]) else $error("valid kept on disabled channel"); // R9
  end
endmodule

bind adc_step_seq adcseq_checker #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_chk (
  .clk(clk), .rstN(rstN), .chEnable(chEnable), .adcStart(adcStart),
  .adcPowerEn(adcPowerEn), .adcChan(adcChan), .validVec(validVec),
  .convTick(convTick)
);

// File: tb/sim_adc_step_seq.sv
module sim_adc_step_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        divWr = 1'b0;
  logic [15:0] divData = '0;
  logic [7:0]  chEnable = '0;
  logic [63:0] openDelay = '0;
  logic [23:0] avgSel = '0;
  logic [2:0]  rdChan = '0;
  logic [11:0] rdData;
  logic        rdValid;
  logic [7:0]  validVec;
  logic        adcPowerEn;
  logic        adcStart;
  logic [2:0]  adcChan;
  logic        adcDone = 1'b0;
  logic [11:0] adcSample = '0;

  always #4 clk = ~clk;

  adc_step_seq u0 (
    .clk(clk), .rstN(rstN), .divWr(divWr), .divData(divData),
    .chEnable(chEnable), .openDelay(openDelay), .avgSel(avgSel),
    .rdChan(rdChan), .rdData(rdData), .rdValid(rdValid), .validVec(validVec),
    .adcPowerEn(adcPowerEn), .adcStart(adcStart), .adcChan(adcChan),
    .adcDone(adcDone), .adcSample(adcSample)
  );

  int nChecks = 0;
  int nErr = 0;
  int cycle = 0;
  int base [8];
  int alt [8];
  int cnt [8];
  int logChan [64];
  int logTime [64];
  int logN = 0;
  bit busy = 0;
  int lat = 0;
  int pendVal = 0;
  bit prevStart = 0;
  bit dblStart = 0;
  bit unpowered = 0;

  always @(posedge clk) cycle++;

  // converter model and start monitor
  always @(negedge clk) begin
    adcDone = 1'b0;
    if (busy) begin
      if (lat == 0) begin
        adcDone = 1'b1;
        adcSample = 12'(pendVal);
        busy = 0;
      end else lat--;
    end
    if (adcStart) begin
      if (prevStart) dblStart = 1;
      if (!adcPowerEn) unpowered = 1;
      pendVal = base[adcChan] + (((cnt[adcChan] & 1) != 0) ? alt[adcChan] : 0);
      cnt[adcChan]++;
      busy = 1;
      lat = 2;
      if (logN < 64) begin
        logChan[logN] = int'(adcChan);
        logTime[logN] = cycle;
        logN++;
      end
    end
    prevStart = adcStart;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic setCh(input int c, input bit en, input int d, input int s,
                       input int b, input int a);
    chEnable[c] = en;
    openDelay[c*8 +: 8] = 8'(d);
    avgSel[c*3 +: 3] = 3'(s);
    base[c] = b;
    alt[c] = a;
  endtask

  task automatic writeDiv(input int v);
    @(negedge clk);
    divWr = 1'b1;
    divData = 16'(v);
    @(negedge clk);
    divWr = 1'b0;
  endtask

  task automatic waitStarts(input int n);
    logN = 0;
    while (logN < n) @(negedge clk);
  endtask

  task automatic readCh(input int c, output int d, output bit v);
    rdChan = 3'(c);
    #1;
    d = int'(rdData);
    v = rdValid;
  endtask

  function automatic int nextEnabled(input int c);
    for (int k = 1; k <= 8; k++)
      if (chEnable[(c + k) % 8]) return (c + k) % 8;
    return c;
  endfunction

  task automatic t_reset();
    int d; bit v;
    @(negedge clk);
    chk(adcPowerEn == 1'b0, "R3 power off after reset", int'(adcPowerEn), 0);
    chk(validVec == 8'h00, "R7 valid flags after reset", int'(validVec), 0);
    readCh(4, d, v);
    chk(v == 1'b0, "R7 rdValid after reset", int'(v), 0);
  endtask

  task automatic t_default_div();
    int d; bit v;
    setCh(0, 1, 0, 0, 100, 0);
    waitStarts(3);
    chk(logTime[2] - logTime[1] == 4800, "R1 default divisor spacing",
        logTime[2] - logTime[1], 4800);
    readCh(0, d, v);
    chk(d == 100 && v, "R7 readback ch0", d, 100);
  endtask

  task automatic t_clamp();
    writeDiv(5);
    waitStarts(5);
    chk(logTime[4] - logTime[3] == 20, "R1 clamp to 10 (R4 D=0)",
        logTime[4] - logTime[3], 20);
  endtask

  task automatic t_delay();
    setCh(0, 1, 5, 0, 100, 0);
    waitStarts(4);
    chk(logTime[3] - logTime[2] == 70, "R4 open delay 5", logTime[3] - logTime[2], 70);
  endtask

  task automatic t_avg2();
    int d; bit v; int i2; int i3; int i4;
    setCh(0, 1, 0, 1, 1000, 3);
    waitStarts(6);
    i2 = logTime[3] - logTime[2];
    i3 = logTime[4] - logTime[3];
    i4 = logTime[5] - logTime[4];
    chk((i2 == 10 && i3 == 20 && i4 == 10) || (i2 == 20 && i3 == 10 && i4 == 20),
        "R5 in-group spacing", i3, 10);
    readCh(0, d, v);
    chk(d == 1001 && v, "R6 truncated mean of 2", d, 1001);
  endtask

  task automatic t_multi();
    int d; bit v; int prev; int runLen; bit first; int expLen [8];
    setCh(0, 0, 0, 0, 0, 0);
    setCh(2, 1, 0, 2, 200, 3);
    setCh(5, 1, 1, 3, 10, 3);
    setCh(7, 1, 0, 6, 4095, 0);
    expLen[2] = 4; expLen[5] = 8; expLen[7] = 16;
    waitStarts(60);
    prev = logChan[0];
    runLen = 1;
    first = 1;
    for (int k = 1; k < 60; k++) begin
      chk(logChan[k] != 0, "R2 disabled ch0 skipped", logChan[k], 2);
      if (logChan[k] == prev) runLen++;
      else begin
        chk(logChan[k] == nextEnabled(prev), "R2 ascending wrap order",
            logChan[k], nextEnabled(prev));
        if (!first) chk(runLen == expLen[prev], "R10 group size", runLen, expLen[prev]);
        first = 0;
        prev = logChan[k];
        runLen = 1;
      end
    end
    readCh(2, d, v);
    chk(d == 201 && v, "R6 mean of 4", d, 201);
    readCh(5, d, v);
    chk(d == 11 && v, "R6 mean of 8", d, 11);
    readCh(7, d, v);
    chk(d == 4095 && v, "R6 full-scale 16 samples", d, 4095);
    chk(validVec == 8'b1010_0100, "R9 valid set only on enabled", int'(validVec), 164);
  endtask

  task automatic t_disable();
    int d; bit v;
    setCh(5, 0, 0, 0, 0, 0);
    @(negedge clk);
    @(negedge clk);
    readCh(5, d, v);
    chk(v == 1'b0, "R9 valid cleared on disable", int'(v), 0);
    chk(validVec[5] == 1'b0, "R9 validVec bit 5", int'(validVec[5]), 0);
    chEnable = '0;
    repeat (40) @(negedge clk);
    chk(adcPowerEn == 1'b0, "R3 power off when all disabled", int'(adcPowerEn), 0);
    logN = 0;
    repeat (300) @(negedge clk);
    chk(logN == 0, "R3 no starts while idle", logN, 0);
    chk(validVec == 8'h00, "R9 all flags cleared", int'(validVec), 0);
  endtask

  task automatic t_newdiv();
    int d; bit v;
    writeDiv(15);
    setCh(3, 1, 0, 0, 500, 0);
    waitStarts(5);
    chk(logTime[4] - logTime[3] == 30, "R1 new divisor 15", logTime[4] - logTime[3], 30);
    readCh(3, d, v);
    chk(d == 500 && v, "R7 readback ch3", d, 500);
    chk(dblStart == 0, "R8 start one clock wide", int'(dblStart), 0);
    chk(unpowered == 0, "R3 start only when powered", int'(unpowered), 0);
  endtask

  task automatic runAll();
    t_reset();
    t_default_div();
    t_clamp();
    t_delay();
    t_avg2();
    t_multi();
    t_disable();
    t_newdiv();
  endtask

  initial begin
    for (int i = 0; i < 8; i++) begin
      base[i] = 0; alt[i] = 0; cnt[i] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    fork
      runAll();
      begin
        repeat (150000) @(posedge clk);
        nChecks++;
        nErr++;
        $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer", cycle);
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule